// File: doc/BRIEF.md
# Coalesced Interrupt Acknowledge Tracker

This block follows one interrupt line that can be delivered to several processors at the same time. It stores two things: a destination map with one bit per processor, and a count of acknowledgements that are still outstanding. When the delivery logic reports that a set of processors accepted the interrupt, the block loads the count with the number of accepting processors and marks them in the map. Each end-of-interrupt from a marked processor removes that processor from the map and lowers the count. While the count is nonzero, `coalesce_o` tells the delivery logic to fold any new assertion of the line into the one already in flight.

After a state load, the tracker can be rebuilt from the processors' real acknowledge state. A single-processor restore corrects one map bit, and the count with it. A full restore takes a snapshot of every processor's pending flag, wipes the tracker, and then walks the processors one per cycle.

The sequencer has three states. `ST_IDLE` accepts requests. `ST_WIPE` clears the tracker for one cycle. `ST_WALK` applies one restore step per processor. The transitions are:

- IDLE to WIPE on a full-restore request.
- WIPE to WALK unconditionally.
- WALK to IDLE after the last processor.
- Any state to IDLE on a clear.

The error output flags an illegal delivery and any decrement at zero.

Top module: `irq_ack_tracker`

## Requirements
- R1: `coalesce_o` is 1 exactly when `pending_cnt_o` is nonzero.
- R2: A delivery loads the count with the number of 1 bits in `deliver_map_i` and ORs `deliver_map_i` into `dest_map_o`. Bit i stands for processor i. Both changes are visible after the next rising edge.
- R3: An end-of-interrupt for processor `eoi_cpu_i` (binary index) whose map bit is set clears that bit and decrements the count. If the bit is clear, count and map do not change.
- R4: Reset, or `clear_i` at a rising edge, leaves the count and the whole map at zero, with `err_o` low and the sequencer in ST_IDLE.
- R5: A single restore compares `restore_pend_i` with the map bit of `restore_cpu_i`. If they differ, it either sets the bit and increments the count, or clears the bit and decrements the count. If they are equal, nothing changes.
- R6: A full restore captures `restore_all_pend_i`, then spends one ST_WIPE cycle and NUM_CPU ST_WALK cycles, so `busy_o` is high for NUM_CPU+1 cycles. At the end the map equals the snapshot and the count equals its number of 1 bits. All requests other than `clear_i` are ignored while busy. A clear aborts the walk.
- R7: A delivery applied while the count is nonzero still takes effect and raises `err_o` for one cycle.
- R8: A decrement requested at a count of zero, by an end-of-interrupt or a restore, leaves the count at zero and raises `err_o` for one cycle.
- R9: When several requests arrive in one idle cycle, only the highest-priority one is applied. The order is clear, then full restore, then single restore, then delivery, then end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous wipe of count and map |
| deliver_i | input | 1 | Delivery report strobe |
| deliver_map_i | input | NUM_CPU | Processors that accepted the delivery |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_cpu_i | input | IDX_W | Processor issuing the end-of-interrupt |
| restore_one_i | input | 1 | Single-processor restore strobe |
| restore_cpu_i | input | IDX_W | Processor being restored |
| restore_pend_i | input | 1 | Actual pending-acknowledge state of that processor |
| restore_all_i | input | 1 | Full-restore strobe |
| restore_all_pend_i | input | NUM_CPU | Pending-acknowledge state of every processor |
| coalesce_o | output | 1 | Drop new assertions of the tracked line |
| pending_cnt_o | output | CNT_W | Outstanding acknowledge count |
| dest_map_o | output | NUM_CPU | Processors still owing an acknowledge |
| busy_o | output | 1 | Full restore in progress |
| err_o | output | 1 | One-cycle pulse on an illegal delivery or an underflow |

## Verification
If the count and the map fall out of step, the fault shows at the ports within one cycle. `coalesce_o` stays high with an empty map, or an end-of-interrupt from a marked processor raises `err_o` at the next edge. A sequencer that skips or repeats a walk step appears as a `busy_o` window of the wrong length, and as a final map that differs from the snapshot one cycle after `busy_o` falls. Random mixes of simultaneous requests expose a wrong priority at the first edge where two requests compete.

// File: rtl/iat_pkg.sv
package iat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WIPE,
        ST_WALK
    } iat_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLEAR,
        OP_DELIVER,
        OP_EOI,
        OP_RESTORE
    } iat_op_e;

endpackage

// File: rtl/iat_popcount.sv
module iat_popcount #(
    parameter int N = 8,
    parameter int W = $clog2(N) + 1
) (
    input  logic [N-1:0] bits_i,
    output logic [W-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + W'(bits_i[i]);
        end
    end

endmodule

// File: rtl/iat_ctrl.sv
module iat_ctrl
    import iat_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = $clog2(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               deliver_i,
    input  logic               eoi_i,
    input  logic [IDX_W-1:0]   eoi_cpu_i,
    input  logic               restore_one_i,
    input  logic [IDX_W-1:0]   restore_cpu_i,
    input  logic               restore_pend_i,
    input  logic               restore_all_i,
    input  logic [NUM_CPU-1:0] restore_all_pend_i,
    output iat_op_e            op_o,
    output logic [IDX_W-1:0]   op_cpu_o,
    output logic               op_pend_o,
    output logic               busy_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPU - 1);

    iat_state_e         state_q, state_d;
    logic [IDX_W-1:0]   walk_idx_q;
    logic [NUM_CPU-1:0] snap_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!clear_i && restore_all_i) state_d = ST_WIPE;
            ST_WIPE: state_d = clear_i ? ST_IDLE : ST_WALK;
            ST_WALK: if (clear_i || walk_idx_q == LAST_IDX) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Walk index and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_idx_q <= '0;
            snap_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && !clear_i && restore_all_i)
                snap_q <= restore_all_pend_i;
            if (state_q == ST_WALK)
                walk_idx_q <= walk_idx_q + IDX_W'(1);
            else
                walk_idx_q <= '0;
        end
    end

    // Outputs: one operation per cycle for the store
    always_comb begin
        op_o      = OP_NONE;
        op_cpu_o  = '0;
        op_pend_o = 1'b0;
        busy_o    = (state_q != ST_IDLE);
        if (clear_i) begin
            op_o = OP_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (restore_all_i) begin
                        op_o = OP_NONE;
                    end else if (restore_one_i) begin
                        op_o      = OP_RESTORE;
                        op_cpu_o  = restore_cpu_i;
                        op_pend_o = restore_pend_i;
                    end else if (deliver_i) begin
                        op_o = OP_DELIVER;
                    end else if (eoi_i) begin
                        op_o     = OP_EOI;
                        op_cpu_o = eoi_cpu_i;
                    end
                end
                ST_WIPE: op_o = OP_CLEAR;
                ST_WALK: begin
                    op_o      = OP_RESTORE;
                    op_cpu_o  = walk_idx_q;
                    op_pend_o = snap_q[walk_idx_q];
                end
                default: op_o = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/iat_store.sv
module iat_store
    import iat_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = $clog2(NUM_CPU),
    parameter int CNT_W   = $clog2(NUM_CPU) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  iat_op_e            op_i,
    input  logic [IDX_W-1:0]   cpu_i,
    input  logic               pend_i,
    input  logic [NUM_CPU-1:0] accept_map_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [NUM_CPU-1:0] map_o,
    output logic               err_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]   cnt_q, cnt_d, accept_cnt;
    logic [NUM_CPU-1:0] map_q, map_d;
    logic               err_q, err_d;

    iat_popcount #(.N(NUM_CPU), .W(CNT_W)) u_pop (
        .bits_i  (accept_map_i),
        .count_o (accept_cnt)
    );

    always_comb begin
        cnt_d = cnt_q;
        map_d = map_q;
        err_d = 1'b0;
        unique case (op_i)
            OP_CLEAR: begin
                cnt_d = '0;
                map_d = '0;
            end
            OP_DELIVER: begin
                err_d = (cnt_q != '0);
                cnt_d = accept_cnt;
                map_d = map_q | accept_map_i;
            end
            OP_EOI: begin
                if (map_q[cpu_i]) begin
                    map_d[cpu_i] = 1'b0;
                    if (cnt_q == '0) err_d = 1'b1;
                    else             cnt_d = cnt_q - CNT_W'(1);
                end
            end
            OP_RESTORE: begin
                if (pend_i != map_q[cpu_i]) begin
                    map_d[cpu_i] = pend_i;
                    if (pend_i) begin
                        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
                    end else if (cnt_q == '0) begin
                        err_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            map_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            map_q <= map_d;
            err_q <= err_d;
        end
    end

    assign cnt_o = cnt_q;
    assign map_o = map_q;
    assign err_o = err_q;

endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import iat_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = $clog2(NUM_CPU),
    parameter int CNT_W   = $clog2(NUM_CPU) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               deliver_i,
    input  logic [NUM_CPU-1:0] deliver_map_i,
    input  logic               eoi_i,
    input  logic [IDX_W-1:0]   eoi_cpu_i,
    input  logic               restore_one_i,
    input  logic [IDX_W-1:0]   restore_cpu_i,
    input  logic               restore_pend_i,
    input  logic               restore_all_i,
    input  logic [NUM_CPU-1:0] restore_all_pend_i,
    output logic               coalesce_o,
    output logic [CNT_W-1:0]   pending_cnt_o,
    output logic [NUM_CPU-1:0] dest_map_o,
    output logic               busy_o,
    output logic               err_o
);

    iat_op_e          op;
    logic [IDX_W-1:0] op_cpu;
    logic             op_pend;

    iat_ctrl #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .clear_i            (clear_i),
        .deliver_i          (deliver_i),
        .eoi_i              (eoi_i),
        .eoi_cpu_i          (eoi_cpu_i),
        .restore_one_i      (restore_one_i),
        .restore_cpu_i      (restore_cpu_i),
        .restore_pend_i     (restore_pend_i),
        .restore_all_i      (restore_all_i),
        .restore_all_pend_i (restore_all_pend_i),
        .op_o               (op),
        .op_cpu_o           (op_cpu),
        .op_pend_o          (op_pend),
        .busy_o             (busy_o)
    );

    iat_store #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .cpu_i        (op_cpu),
        .pend_i       (op_pend),
        .accept_map_i (deliver_map_i),
        .cnt_o        (pending_cnt_o),
        .map_o        (dest_map_o),
        .err_o        (err_o)
    );

    assign coalesce_o = (pending_cnt_o != '0);

endmodule

// File: rtl/iat_checker.sv
module iat_checker #(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = $clog2(NUM_CPU),
    parameter int CNT_W   = $clog2(NUM_CPU) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear_i,
    input logic               deliver_i,
    input logic [NUM_CPU-1:0] deliver_map_i,
    input logic               eoi_i,
    input logic [IDX_W-1:0]   eoi_cpu_i,
    input logic               restore_one_i,
    input logic [IDX_W-1:0]   restore_cpu_i,
    input logic               restore_pend_i,
    input logic               restore_all_i,
    input logic               busy_o,
    input logic               err_o,
    input logic [CNT_W-1:0]   pending_cnt_o,
    input logic [NUM_CPU-1:0] dest_map_o
);

    logic free_slot;
    assign free_slot = !clear_i && !restore_all_i && !busy_o;

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pending_cnt_o == '0) && (dest_map_o == '0) && !err_o && !busy_o);

    a_r2_deliver_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slot && !restore_one_i && deliver_i)
        |=> (int'(pending_cnt_o) == $countones($past(deliver_map_i)))
            && ((dest_map_o & $past(deliver_map_i)) == $past(deliver_map_i)));

    a_r7_late_delivery_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slot && !restore_one_i && deliver_i && pending_cnt_o != '0) |=> err_o);

    a_r3_unmarked_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slot && !restore_one_i && !deliver_i && eoi_i && !dest_map_o[eoi_cpu_i])
        |=> $stable(pending_cnt_o) && $stable(dest_map_o) && !err_o);

    a_r5_matching_restore_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slot && restore_one_i && restore_pend_i == dest_map_o[restore_cpu_i])
        |=> $stable(pending_cnt_o) && $stable(dest_map_o) && !err_o);

    a_r8_no_wrap_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_cnt_o == '0 && !deliver_i && !restore_one_i && !restore_all_i && !busy_o)
        |=> pending_cnt_o == '0);

endmodule

bind irq_ack_tracker iat_checker #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .deliver_i     (deliver_i),
    .deliver_map_i (deliver_map_i),
    .eoi_i         (eoi_i),
    .eoi_cpu_i     (eoi_cpu_i),
    .restore_one_i (restore_one_i),
    .restore_cpu_i (restore_cpu_i),
    .restore_pend_i(restore_pend_i),
    .restore_all_i (restore_all_i),
    .busy_o        (busy_o),
    .err_o         (err_o),
    .pending_cnt_o (pending_cnt_o),
    .dest_map_o    (dest_map_o)
);

// File: tb/irq_ack_tracker_bench.sv
`timescale 1ns/1ps
module irq_ack_tracker_bench;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 0, deliver_i = 0, eoi_i = 0;
    logic          restore_one_i = 0, restore_pend_i = 0, restore_all_i = 0;
    logic [N-1:0]  deliver_map_i = '0, restore_all_pend_i = '0;
    logic [IW-1:0] eoi_cpu_i = '0, restore_cpu_i = '0;
    logic          coalesce_o, busy_o, err_o;
    logic [CW-1:0] pending_cnt_o;
    logic [N-1:0]  dest_map_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [CW-1:0] m_cnt = '0;
    logic [N-1:0]  m_map = '0;
    logic          m_err = 1'b0;

    always #5 clk = ~clk;

    irq_ack_tracker #(.NUM_CPU(N)) u_irq_ack_tracker (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .deliver_i(deliver_i), .deliver_map_i(deliver_map_i),
        .eoi_i(eoi_i), .eoi_cpu_i(eoi_cpu_i),
        .restore_one_i(restore_one_i), .restore_cpu_i(restore_cpu_i),
        .restore_pend_i(restore_pend_i), .restore_all_i(restore_all_i),
        .restore_all_pend_i(restore_all_pend_i),
        .coalesce_o(coalesce_o), .pending_cnt_o(pending_cnt_o),
        .dest_map_o(dest_map_o), .busy_o(busy_o), .err_o(err_o)
    );

    function automatic logic [CW-1:0] ones(logic [N-1:0] v);
        logic [CW-1:0] c = '0;
        for (int i = 0; i < N; i++) c = c + CW'(v[i]);
        return c;
    endfunction

    task automatic check_outputs(string tag, logic exp_busy);
        checks++;
        if (pending_cnt_o !== m_cnt || dest_map_o !== m_map || coalesce_o !== (m_cnt != 0)
            || err_o !== m_err || busy_o !== exp_busy) begin
            fails++;
            $display("FAIL %s/R1: cnt=%0d map=%h coal=%b err=%b busy=%b expected cnt=%0d map=%h coal=%b err=%b busy=%b",
                     tag, pending_cnt_o, dest_map_o, coalesce_o, err_o, busy_o,
                     m_cnt, m_map, (m_cnt != 0), m_err, exp_busy);
        end
    endtask

    task automatic drive_idle();
        clear_i = 0; deliver_i = 0; eoi_i = 0; restore_one_i = 0; restore_all_i = 0;
        deliver_map_i = '0; eoi_cpu_i = '0; restore_cpu_i = '0; restore_pend_i = 0;
        restore_all_pend_i = '0;
    endtask

    // Bench model of one idle-cycle request set, priority per R9
    task automatic do_op(logic c, logic ro, logic [IW-1:0] rc, logic rp,
                         logic d, logic [N-1:0] dm, logic e, logic [IW-1:0] ec);
        string tag;
        clear_i = c; restore_one_i = ro; restore_cpu_i = rc; restore_pend_i = rp;
        deliver_i = d; deliver_map_i = dm; eoi_i = e; eoi_cpu_i = ec;
        m_err = 1'b0;
        if (c) begin
            tag = "R4"; m_cnt = '0; m_map = '0;
        end else if (ro) begin
            tag = "R5";
            if (rp != m_map[rc]) begin
                m_map[rc] = rp;
                if (rp) m_cnt = m_cnt + 1'b1;
                else if (m_cnt == 0) begin m_err = 1'b1; tag = "R8"; end
                else m_cnt = m_cnt - 1'b1;
            end
        end else if (d) begin
            tag = (m_cnt != 0) ? "R7" : "R2";
            m_err = (m_cnt != 0);
            m_cnt = ones(dm);
            m_map = m_map | dm;
        end else if (e) begin
            tag = "R3";
            if (m_map[ec]) begin
                m_map[ec] = 1'b0;
                if (m_cnt == 0) begin m_err = 1'b1; tag = "R8"; end
                else m_cnt = m_cnt - 1'b1;
            end
        end else begin
            tag = "R1";
        end
        if ((c + ro + d + e) > 1) tag = {tag, "+R9"};
        @(posedge clk);
        @(negedge clk);
        drive_idle();
        check_outputs(tag, 1'b0);
    endtask

    task automatic run_restore_all(logic [N-1:0] snap);
        restore_all_i = 1; restore_all_pend_i = snap;
        @(posedge clk); @(negedge clk);
        // ignored while busy
        restore_all_i = 0; deliver_i = 1; deliver_map_i = '1; eoi_i = 1; eoi_cpu_i = 3'd2;
        restore_one_i = 1; restore_cpu_i = 3'd0; restore_pend_i = ~snap[0];
        checks++;
        if (busy_o !== 1'b1) begin fails++; $display("FAIL R6: busy=%b expected 1 at step 1", busy_o); end
        for (int k = 2; k <= N + 1; k++) begin
            @(posedge clk); @(negedge clk);
            checks++;
            if (busy_o !== 1'b1) begin fails++; $display("FAIL R6: busy=%b expected 1 at step %0d", busy_o, k); end
        end
        @(posedge clk); @(negedge clk);
        drive_idle();
        m_map = snap; m_cnt = ones(snap); m_err = 1'b0;
        check_outputs("R6", 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_outputs("R4", 1'b0);

        // directed corners
        do_op(0, 0, 0, 0, 1, 8'b0000_1011, 0, 0);  // R2 deliver three
        do_op(0, 0, 0, 0, 0, '0, 1, 3'd2);         // R3 unmarked eoi
        do_op(0, 0, 0, 0, 0, '0, 1, 3'd1);         // R3 marked eoi
        do_op(0, 0, 0, 0, 1, 8'h10, 0, 0);         // R7 delivery with count 2
        do_op(0, 0, 0, 0, 0, '0, 1, 3'd0);         // R3 to zero
        do_op(0, 0, 0, 0, 0, '0, 1, 3'd3);         // R8 underflow by eoi
        do_op(1, 0, 0, 0, 0, '0, 0, 0);            // R4 clear
        do_op(0, 1, 3'd5, 1, 0, '0, 0, 0);         // R5 set
        do_op(0, 1, 3'd5, 1, 0, '0, 0, 0);         // R5 match
        do_op(0, 1, 3'd5, 0, 0, '0, 0, 0);         // R5 clear
        do_op(0, 1, 3'd4, 0, 0, '0, 0, 0);         // R5 match zero
        do_op(1, 1, 3'd1, 1, 1, 8'hFF, 1, 3'd1);   // R9 clear wins
        do_op(0, 1, 3'd6, 1, 1, 8'hFF, 1, 3'd6);   // R9 restore wins
        do_op(0, 0, 0, 0, 1, 8'h03, 1, 3'd6);      // R9 deliver wins (R7)
        do_op(0, 1, 3'd6, 0, 0, '0, 0, 0);         // R5 clear bit
        do_op(0, 1, 3'd0, 0, 0, '0, 0, 0);
        do_op(0, 1, 3'd1, 0, 0, '0, 0, 0);         // R8 underflow by restore

        run_restore_all(8'hA5);                    // R6 full walk
        // R6 abort by clear
        restore_all_i = 1; restore_all_pend_i = 8'hFF;
        repeat (3) begin @(posedge clk); @(negedge clk); restore_all_i = 0; end
        clear_i = 1; m_cnt = '0; m_map = '0; m_err = 0;
        @(posedge clk); @(negedge clk);
        drive_idle();
        check_outputs("R6-abort", 1'b0);
        @(posedge clk); @(negedge clk);
        check_outputs("R6-abort-held", 1'b0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic c, ro, d, e;
            c  = ($urandom % 16) == 0;
            ro = ($urandom % 4) == 0;
            d  = ($urandom % 5) == 0;
            e  = ($urandom % 2) == 0;
            do_op(c, ro, IW'($urandom), 1'($urandom), d, N'($urandom) & N'($urandom), e, IW'($urandom));
            if ((i % 500) == 499) run_restore_all(N'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule